// File: doc/BRIEF.md
# Widening Integer ALU with Split Result Words

This block is a streaming element-wise integer ALU. Each accepted element supplies a first operand and, in tensor-tensor mode, a second operand. In tensor-scalar mode the second operand comes from a held scalar register. Both operands are extended to 64 bits according to their declared type. The selected operation then produces a full 64-bit result. That result leaves the block as two 32-bit words: bits 31:0 on the low output and bits 63:32 on the high output. The carry, borrow, upper product bits or shifted-out bits therefore appear on the high word instead of being lost.

A configuration port loads the operation code, the mode, the scalar and the types of the second operand and of both result words. Every element is checked against the active configuration and against its own type tag. The first element that breaks a rule raises a sticky error. That element and every later one are consumed and dropped until the configuration is written again. The datapath has one register stage, and both streams use valid/ready handshakes.

Top module: `wide_alu`

## Requirements
- R1: The legal operation codes are 0xC4 add, 0xC6 subtract, 0xC5 signed multiply, 0xDB unsigned multiply, 0x02 arithmetic shift left, 0x03 arithmetic shift right, 0x10 logical shift left and 0x11 logical shift right. `op_bad_o` is high whenever the loaded code is any other value. An element offered under such a code sets the error.
- R2: `out_lo_o` carries bits 31:0 and `out_hi_o` carries bits 63:32 of the 64-bit result. For add, the high word is the carry (0 or 1). For subtract, it is the borrow (0 or all ones). For multiply, it is the upper product.
- R3: Add, subtract and unsigned multiply require both operand types to be unsigned. Signed multiply requires both to be signed. Any other combination sets the error.
- R4: For shifts, the second operand's type must be unsigned, and its extended value is the shift amount. Amounts of 64 or more give zero, or sign fill for the arithmetic right shift. Logical shifts zero-extend the first operand. In scalar mode, a shift whose scalar has any of bits 31:5 set sets the error.
- R5: A type code is {sign bit[2], width bits[1:0]}, where the width is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Width code 3 on any type sets the error. An operand is extended from its low bits by its type, and its raw upper bits are ignored.
- R6: In scalar mode, the scalar register replaces `in_src1_i`, and `in_src1_i` has no effect. The element's tag and the scalar type must agree in signedness, or the error is set.
- R7: For non-shift operations, the low-word width must be 32 bits, and the sign bit of the high-word type must equal the sign of the first operand's tag. A violation sets the error.
- R8: A legal element accepted at an edge appears on the output at that edge with `out_valid_o` high. While `out_ready_i` is low, the output is held stable and `in_ready_o` is low.
- R9: The error rises on the edge that accepts an offending element, and that element yields no output. While the error is set, `in_ready_o` is high and elements are dropped without output. A configuration write clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load configuration and clear error |
| cfg_op_i | input | 8 | Operation code |
| cfg_ts_mode_i | input | 1 | 1: second operand from scalar |
| cfg_scalar_i | input | 32 | Scalar value |
| cfg_src1_type_i | input | 3 | Type of second operand or scalar |
| cfg_lo_w_i | input | 2 | Width code of low result word |
| cfg_hi_type_i | input | 3 | Type of high result word |
| in_valid_i | input | 1 | Element valid |
| in_ready_o | output | 1 | Element accepted |
| in_src0_i | input | 32 | First operand |
| in_src1_i | input | 32 | Second operand (tensor mode) |
| in_type_i | input | 3 | Type tag of first operand |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_lo_o | output | 32 | Result bits 31:0 |
| out_hi_o | output | 32 | Result bits 63:32 |
| op_bad_o | output | 1 | Loaded op code is not legal |
| err_o | output | 1 | Sticky configuration error |

## Verification
A result or an error is due on the single clock edge that accepts the element. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, so each check reads exactly that first registered state. `op_bad_o` follows the configuration register, so it is read once the loading edge has passed. The backpressure checks sample on two successive edges with `out_ready_i` low and then one edge after it returns high. This shows the hold and the back-to-back transfer.

// File: rtl/wide_alu_pkg.sv
`timescale 1ns/1ps
package wide_alu_pkg;
  localparam logic [7:0] OP_ADD  = 8'hC4;
  localparam logic [7:0] OP_MULS = 8'hC5;
  localparam logic [7:0] OP_SUB  = 8'hC6;
  localparam logic [7:0] OP_MULU = 8'hDB;
  localparam logic [7:0] OP_ASL  = 8'h02;
  localparam logic [7:0] OP_ASR  = 8'h03;
  localparam logic [7:0] OP_LSL  = 8'h10;
  localparam logic [7:0] OP_LSR  = 8'h11;

  localparam logic [1:0] W8  = 2'd0;
  localparam logic [1:0] W16 = 2'd1;
  localparam logic [1:0] W32 = 2'd2;
  localparam logic [1:0] WXX = 2'd3;

  typedef struct packed {
    logic       sgn;
    logic [1:0] w;
  } etype_t;
endpackage

// File: rtl/wide_alu_ext.sv
`timescale 1ns/1ps
module wide_alu_ext
  import wide_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 64
) (
  input  logic [DW-1:0] raw_i,
  input  logic [2:0]    ty_i,
  input  logic          zx_i,
  output logic [RW-1:0] ext_o
);
  etype_t t;
  logic   sg;

  always_comb begin
    t  = ty_i;
    sg = t.sgn & ~zx_i;
    unique case (t.w)
      W8:      ext_o = {{(RW-8){sg & raw_i[7]}}, raw_i[7:0]};
      W16:     ext_o = {{(RW-16){sg & raw_i[15]}}, raw_i[15:0]};
      default: ext_o = {{(RW-DW){sg & raw_i[DW-1]}}, raw_i};
    endcase
  end
endmodule

// File: rtl/wide_alu_legal.sv
`timescale 1ns/1ps
module wide_alu_legal
  import wide_alu_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       ts_i,
  input  logic       scal_big_i,
  input  logic [2:0] s0_i,
  input  logic [2:0] s1_i,
  input  logic [1:0] lo_w_i,
  input  logic [2:0] hi_i,
  output logic       op_ok_o,
  output logic       legal_o
);
  etype_t t0, t1, th;
  logic is_add, is_sub, is_muls, is_mulu, is_shift;
  logic w_ok, sg_ok, ts_ok, dst_ok;

  always_comb begin
    t0 = s0_i;
    t1 = s1_i;
    th = hi_i;
    is_add   = op_i == OP_ADD;
    is_sub   = op_i == OP_SUB;
    is_muls  = op_i == OP_MULS;
    is_mulu  = op_i == OP_MULU;
    is_shift = (op_i == OP_ASL) | (op_i == OP_ASR) | (op_i == OP_LSL) | (op_i == OP_LSR);
    op_ok_o  = is_add | is_sub | is_muls | is_mulu | is_shift;

    w_ok = (t0.w != WXX) & (t1.w != WXX) & (lo_w_i != WXX) & (th.w != WXX);

    if (is_add | is_sub | is_mulu) sg_ok = ~t0.sgn & ~t1.sgn;
    else if (is_muls)              sg_ok = t0.sgn & t1.sgn;
    else                           sg_ok = ~t1.sgn;

    ts_ok  = ~ts_i | ((t0.sgn == t1.sgn) & ~(is_shift & scal_big_i));
    dst_ok = is_shift | ((lo_w_i == W32) & (th.sgn == t0.sgn));

    legal_o = op_ok_o & w_ok & sg_ok & ts_ok & dst_ok;
  end
endmodule

// File: rtl/wide_alu_core.sv
`timescale 1ns/1ps
module wide_alu_core #(
  parameter int RW = 64
) (
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] b_i,
  input  logic          arith_i,
  input  logic [1:0]    sel_i,
  input  logic          right_i,
  input  logic          logic_i,
  output logic [RW-1:0] res_o
);
  localparam int SHW = $clog2(RW);

  logic [RW-1:0]  ar, sh;
  logic           big;
  logic [SHW-1:0] amt;

  always_comb begin
    big = |b_i[RW-1:SHW];
    amt = b_i[SHW-1:0];
    // both operands arrive fully extended, so the low RW product bits are exact
    unique case (sel_i)
      2'b00:   ar = a_i + b_i;
      2'b10:   ar = a_i - b_i;
      default: ar = a_i * b_i;
    endcase
    if (!right_i)     sh = big ? '0 : a_i << amt;
    else if (logic_i) sh = big ? '0 : a_i >> amt;
    else              sh = big ? {RW{a_i[RW-1]}} : RW'($signed(a_i) >>> amt);
    res_o = arith_i ? ar : sh;
  end
endmodule

// File: rtl/wide_alu.sv
`timescale 1ns/1ps
module wide_alu
  import wide_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_op_i,
  input  logic          cfg_ts_mode_i,
  input  logic [DW-1:0] cfg_scalar_i,
  input  logic [2:0]    cfg_src1_type_i,
  input  logic [1:0]    cfg_lo_w_i,
  input  logic [2:0]    cfg_hi_type_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_src0_i,
  input  logic [DW-1:0] in_src1_i,
  input  logic [2:0]    in_type_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_lo_o,
  output logic [DW-1:0] out_hi_o,
  output logic          op_bad_o,
  output logic          err_o
);
  localparam int RW  = 2 * DW;
  localparam int SHW = $clog2(DW);

  logic [7:0]    op_q;
  logic          ts_q;
  logic [DW-1:0] scalar_q;
  logic [2:0]    t1_q, hi_t_q;
  logic [1:0]    lo_w_q;
  logic          err_q, ov_q;
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_ADD;
      ts_q     <= 1'b0;
      scalar_q <= '0;
      t1_q     <= {1'b0, W32};
      lo_w_q   <= W32;
      hi_t_q   <= {1'b0, W32};
    end else if (cfg_we_i) begin
      op_q     <= cfg_op_i;
      ts_q     <= cfg_ts_mode_i;
      scalar_q <= cfg_scalar_i;
      t1_q     <= cfg_src1_type_i;
      lo_w_q   <= cfg_lo_w_i;
      hi_t_q   <= cfg_hi_type_i;
    end
  end

  logic is_arith, op_ok, legal, in_fire, take, bad;
  assign is_arith = op_q[7] & op_q[6];

  wide_alu_legal u_legal (
    .op_i       (op_q),
    .ts_i       (ts_q),
    .scal_big_i (|scalar_q[DW-1:SHW]),
    .s0_i       (in_type_i),
    .s1_i       (t1_q),
    .lo_w_i     (lo_w_q),
    .hi_i       (hi_t_q),
    .op_ok_o    (op_ok),
    .legal_o    (legal)
  );

  logic [DW-1:0] raw_w [2];
  logic [2:0]    ty_w  [2];
  logic          zx_w  [2];
  logic [RW-1:0] ext_w [2];

  assign raw_w[0] = in_src0_i;
  assign raw_w[1] = ts_q ? scalar_q : in_src1_i;
  assign ty_w[0]  = in_type_i;
  assign ty_w[1]  = t1_q;
  assign zx_w[0]  = ~is_arith & op_q[4];
  assign zx_w[1]  = 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    wide_alu_ext #(.DW(DW), .RW(RW)) u_ext (
      .raw_i (raw_w[g]),
      .ty_i  (ty_w[g]),
      .zx_i  (zx_w[g]),
      .ext_o (ext_w[g])
    );
  end

  logic [RW-1:0] res;
  wide_alu_core #(.RW(RW)) u_core (
    .a_i     (ext_w[0]),
    .b_i     (ext_w[1]),
    .arith_i (is_arith),
    .sel_i   (op_q[1:0]),
    .right_i (op_q[0]),
    .logic_i (op_q[4]),
    .res_o   (res)
  );

  assign in_ready_o = err_q | ~ov_q | out_ready_i;
  assign in_fire    = in_valid_i & in_ready_o;
  assign take       = in_fire & ~err_q & legal;
  assign bad        = in_fire & ~err_q & ~legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      ov_q  <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (cfg_we_i) err_q <= 1'b0;
      else if (bad) err_q <= 1'b1;
      if (take) begin
        ov_q <= 1'b1;
        lo_q <= res[DW-1:0];
        hi_q <= res[RW-1:DW];
      end else if (out_ready_i) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign out_lo_o    = lo_q;
  assign out_hi_o    = hi_q;
  assign op_bad_o    = ~op_ok;
  assign err_o       = err_q;

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ov_q);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && !out_ready_i) |=> (ov_q && $stable(lo_q) && $stable(hi_q)));
  a_r9_no_output_in_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !ov_q) |=> !ov_q);
  a_r1_bad_op_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_bad_o && in_fire && !err_q && !cfg_we_i) |=> err_q);
  a_r2_add_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_q == OP_ADD) |=> (hi_q <= DW'(1)));
  a_r2_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_q == OP_SUB) |=> (hi_q == '0 || hi_q == '1));
endmodule

// File: tb/wide_alu_tb_top.sv
`timescale 1ns/1ps
module wide_alu_tb_top;
  localparam logic [7:0] ADD = 8'hC4, MULS = 8'hC5, SUB = 8'hC6, MULU = 8'hDB;
  localparam logic [7:0] ASL = 8'h02, ASR = 8'h03, LSL = 8'h10, LSR = 8'h11;
  localparam logic [2:0] U8 = 3'b000, U16 = 3'b001, U32 = 3'b010;
  localparam logic [2:0] S8 = 3'b100, S16 = 3'b101, S32 = 3'b110, UBAD = 3'b011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_ts = 0, in_valid = 0, out_ready = 1;
  logic [7:0] cfg_op = ADD;
  logic [31:0] cfg_sc = 0, src0 = 0, src1 = 0;
  logic [2:0] cfg_t1 = U32, cfg_hi = U32, in_ty = U32;
  logic [1:0] cfg_lo = 2'd2;
  logic in_ready, out_valid, op_bad, err;
  logic [31:0] out_lo, out_hi;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wide_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_op_i(cfg_op),
    .cfg_ts_mode_i(cfg_ts), .cfg_scalar_i(cfg_sc), .cfg_src1_type_i(cfg_t1),
    .cfg_lo_w_i(cfg_lo), .cfg_hi_type_i(cfg_hi), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_src0_i(src0), .in_src1_i(src1), .in_type_i(in_ty),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_lo_o(out_lo),
    .out_hi_o(out_hi), .op_bad_o(op_bad), .err_o(err)
  );

  function automatic logic [63:0] bext(logic [31:0] r, logic [2:0] t, logic zx);
    logic s = t[2] & ~zx;
    case (t[1:0])
      2'd0:    return {{56{s & r[7]}}, r[7:0]};
      2'd1:    return {{48{s & r[15]}}, r[15:0]};
      default: return {{32{s & r[31]}}, r};
    endcase
  endfunction

  function automatic logic [63:0] ref_res(logic [7:0] op, logic [31:0] a, logic [31:0] b,
                                          logic [2:0] t0, logic [2:0] t1);
    logic [63:0] x = bext(a, t0, op == LSL || op == LSR);
    logic [63:0] y = bext(b, t1, 1'b0);
    case (op)
      ADD:       return x + y;
      SUB:       return x - y;
      MULS, MULU: return x * y;
      ASL, LSL:  return (y > 63) ? 64'd0 : x << y[5:0];
      ASR:       return (y > 63) ? {64{x[63]}} : 64'($signed(x) >>> y[5:0]);
      default:   return (y > 63) ? 64'd0 : x >> y[5:0];
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cfg(logic [7:0] op, logic ts, logic [31:0] sc, logic [2:0] t1,
                        logic [1:0] lo, logic [2:0] hi);
    @(negedge clk);
    cfg_we = 1; cfg_op = op; cfg_ts = ts; cfg_sc = sc; cfg_t1 = t1; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(logic [31:0] a, logic [31:0] b, logic [2:0] t0);
    @(negedge clk);
    in_valid = 1; src0 = a; src1 = b; in_ty = t0;
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // element then compare both words one edge after acceptance
  task automatic run1(string req, logic [31:0] a, logic [31:0] b, logic [2:0] t0);
    logic [63:0] e = ref_res(cfg_op, a, b, t0, cfg_ts ? cfg_t1 : cfg_t1);
    push(a, cfg_ts ? b : b, t0);
    if (cfg_ts) e = ref_res(cfg_op, a, cfg_sc, t0, cfg_t1);
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, {out_hi, out_lo}, e);
  endtask

  task automatic t_reset;
    chk("R8 reset valid", {63'd0, out_valid}, 0);
    chk("R9 reset err", {63'd0, err}, 0);
    chk("R1 reset op_bad", {63'd0, op_bad}, 0);
    chk("R8 reset ready", {63'd0, in_ready}, 1);
  endtask

  task automatic t_edges;
    logic [31:0] ev[3] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000};
    logic [7:0] uops[3] = '{ADD, SUB, MULU};
    foreach (uops[k]) begin
      do_cfg(uops[k], 0, 0, U32, 2'd2, U32);
      chk("R1 legal op_bad", {63'd0, op_bad}, 0);
      foreach (ev[i]) foreach (ev[j]) run1("R2 edge unsigned", ev[i], ev[j], U32);
    end
    do_cfg(MULS, 0, 0, S32, 2'd2, S32);
    foreach (ev[i]) foreach (ev[j]) run1("R2 edge signed mul", ev[i], ev[j], S32);
    do_cfg(ADD, 0, 0, U32, 2'd2, U32);
    run1("R2 carry", 32'hFFFF_FFFF, 32'h1, U32);
    chk("R2 carry hi", {32'd0, out_hi}, 1);
    do_cfg(SUB, 0, 0, U32, 2'd2, U32);
    run1("R2 borrow", 32'h0, 32'h1, U32);
    chk("R2 borrow hi", {32'd0, out_hi}, 64'hFFFF_FFFF);
  endtask

  task automatic t_narrow;
    do_cfg(MULS, 0, 0, S16, 2'd2, S32);
    run1("R5 s8 x s16", 32'h1234_56FF, 32'hFFFF_AB80, S8);
    chk("R5 s8 x s16 value", {out_hi, out_lo}, 64'h0000_0000_0000_5480);
    do_cfg(ADD, 0, 0, U8, 2'd2, U16);
    run1("R5 u16 + u8", 32'hDEAD_FFFF, 32'h1234_56FF, U16);
    chk("R5 u16 + u8 value", {out_hi, out_lo}, 64'h0000_0000_0001_00FE);
  endtask

  task automatic t_shifts;
    do_cfg(LSL, 0, 0, U32, 2'd2, U32);
    run1("R4 lsl signed src zero-ext", 32'hF000_0001, 32'd4, S32);
    chk("R4 lsl high bits", {out_hi, out_lo}, 64'h0000_000F_0000_0010);
    do_cfg(ASL, 0, 0, U32, 2'd2, U32);
    run1("R4 asl sign-ext", 32'hF000_0001, 32'd4, S32);
    do_cfg(ASR, 0, 0, U32, 2'd2, U32);
    run1("R4 asr big amount", 32'h8000_0000, 32'd70, S32);
    chk("R4 asr fill", {out_hi, out_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    do_cfg(LSR, 1, 32'd31, U32, 2'd2, U32);
    run1("R4 lsr scalar 31", 32'h8000_0000, 32'hAAAA_AAAA, U32);
  endtask

  task automatic t_scalar;
    do_cfg(ADD, 1, 32'hFFFF_FFFF, U32, 2'd2, U32);
    run1("R6 scalar add", 32'd2, 32'h1234_5678, U32);
    chk("R6 src1 ignored", {out_hi, out_lo}, 64'h1_0000_0001);
    run1("R6 scalar add b", 32'd0, 32'hFFFF_FFFF, U32);
    chk("R6 src1 ignored b", {out_hi, out_lo}, 64'h0_FFFF_FFFF);
  endtask

  task automatic bad(string req, logic [7:0] op, logic ts, logic [31:0] sc, logic [2:0] t1,
                     logic [1:0] lo, logic [2:0] hi, logic [2:0] t0);
    do_cfg(op, ts, sc, t1, lo, hi);
    push(32'd3, 32'd1, t0);
    chk({req, " err"}, {63'd0, err}, 1);
    chk({req, " no output"}, {63'd0, out_valid}, 0);
    do_cfg(ADD, 0, 0, U32, 2'd2, U32);
    chk({req, " cleared"}, {63'd0, err}, 0);
  endtask

  task automatic t_illegal;
    bad("R3 add signed src0", ADD, 0, 0, U32, 2'd2, S32, S32);
    bad("R3 sub signed src1", SUB, 0, 0, S32, 2'd2, U32, U32);
    bad("R3 muls unsigned src1", MULS, 0, 0, U32, 2'd2, S32, S32);
    bad("R3 mulu signed src0", MULU, 0, 0, U32, 2'd2, S32, S32);
    bad("R4 shift signed amount", LSL, 0, 0, S32, 2'd2, U32, U32);
    bad("R4 scalar shift 32", LSL, 1, 32'd32, U32, 2'd2, U32, U32);
    bad("R5 width code 3", ADD, 0, 0, U32, 2'd2, U32, UBAD);
    bad("R6 scalar sign mismatch", ASR, 1, 32'd1, U32, 2'd2, U32, S32);
    bad("R7 low width 16", ADD, 0, 0, U32, 2'd1, U32, U32);
    bad("R7 high sign mismatch", ADD, 0, 0, U32, 2'd2, S32, U32);
  endtask

  task automatic t_sticky;
    do_cfg(8'h41, 0, 0, U32, 2'd2, U32);
    chk("R1 op_bad flag", {63'd0, op_bad}, 1);
    push(32'd1, 32'd2, U32);
    chk("R1 bad op err", {63'd0, err}, 1);
    @(negedge clk);
    chk("R9 ready while err", {63'd0, in_ready}, 1);
    push(32'd1, 32'd2, U32);
    chk("R9 dropped", {63'd0, out_valid}, 0);
    chk("R9 sticky", {63'd0, err}, 1);
    do_cfg(ADD, 0, 0, U32, 2'd2, U32);
    chk("R9 cleared", {63'd0, err}, 0);
    chk("R1 op_bad clear", {63'd0, op_bad}, 0);
    run1("R9 after clear", 32'd1, 32'd2, U32);
  endtask

  task automatic t_backpressure;
    do_cfg(ADD, 0, 0, U32, 2'd2, U32);
    @(negedge clk); out_ready = 0;
    run1("R8 first", 32'd5, 32'd7, U32);
    @(negedge clk);
    in_valid = 1; src0 = 1; src1 = 1; in_ty = U32;
    chk("R8 ready low", {63'd0, in_ready}, 0);
    @(posedge clk); #1;
    chk("R8 held valid", {63'd0, out_valid}, 1);
    chk("R8 held data", {out_hi, out_lo}, 64'd12);
    @(negedge clk); out_ready = 1;
    @(posedge clk); #1 in_valid = 0;
    chk("R8 next data", {out_hi, out_lo}, 64'd2);
  endtask

  task automatic rnd(string req, logic [7:0] op, logic [2:0] t0, logic [2:0] t1,
                     logic [2:0] hi, int n, logic [31:0] bmask);
    do_cfg(op, 0, 0, t1, 2'd2, hi);
    for (int i = 0; i < n; i++) run1(req, $urandom, $urandom & bmask, t0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_narrow();
    t_shifts();
    t_scalar();
    t_illegal();
    t_sticky();
    t_backpressure();
    rnd("R2 rand add", ADD, U32, U32, U32, 40, '1);
    rnd("R2 rand sub", SUB, U32, U16, U32, 40, '1);
    rnd("R2 rand mulu", MULU, U32, U32, U32, 40, '1);
    rnd("R2 rand muls", MULS, S32, S16, S32, 40, '1);
    rnd("R4 rand asl", ASL, S32, U8, U32, 40, '1);
    rnd("R4 rand asr", ASR, S16, U32, U32, 40, 32'h3F);
    rnd("R4 rand lsr", LSR, U32, U32, U32, 40, 32'h7F);
    rnd("R4 rand lsl", LSL, S8, U8, U32, 40, '1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #750000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule